// File: doc/BRIEF.md
# Split-Operand Wide Multiplier

This block multiplies two unsigned operands of 2n bits each. It produces the full 4n-bit product by splitting each operand into a high half and a low half of n bits. Four small n×n multiplier instances then form the four cross products. The products are stacked with the low-by-low and high-by-high products side by side in one row, and the two mixed products sit beneath them starting at column n. This stack is at most three rows tall.

In the lowest n columns only the low-by-low product has bits, so those columns are copied straight to the result. The 2n centre columns are reduced from three rows to two by a single row of 3:2 carry-save cells. One 3n-bit carry-propagate adder then combines the saved sum, the shifted saved carry and the upper half of the high-by-high product.

A register stage follows the small multipliers and a second one follows the final adder. A result therefore appears two cycles after its operands are accepted, and a new pair can be accepted every cycle.

Top module: `wide_mul_split`

## Requirements
- R1: `out_valid` is high in the cycle after the second rising clock edge that follows a cycle in which `in_valid` was sampled high, and low otherwise.
- R2: When `out_valid` is high, `prod_out` equals the exact unsigned product of the `a_in` and `x_in` values that were presented with the matching `in_valid`, with all 4n bits correct, including the all-ones times all-ones case.
- R3: When `out_valid` is high, bits [n-1:0] of `prod_out` equal the low n bits of the product of the low halves (`a_in[n-1:0]` × `x_in[n-1:0]`).
- R4: While `rst_n` is low, `out_valid` is 0 and `prod_out` is all zeros, whatever the clock does.
- R5: Operand values presented with `in_valid` low have no effect. `prod_out` keeps the last valid result while `out_valid` is low.
- R6: Operand pairs presented on consecutive cycles give results on consecutive cycles, in the same order.
- R7: The half width n is the parameter `HALF_W`. The block is correct at n = 4 (8×8 bits) and at n = 8 (16×16 bits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on `a_in`/`x_in` are to be multiplied |
| a_in | input | 2*HALF_W | Multiplicand, unsigned |
| x_in | input | 2*HALF_W | Multiplier, unsigned |
| out_valid | output | 1 | `prod_out` carries a new result |
| prod_out | output | 4*HALF_W | Full unsigned product |

## Verification
The hardest case to reach from the ports is a carry that starts in the centre columns and must travel through the top half of the high-by-high product, up to the last output bit. This only happens when both saved rows and the upper product bits are nearly all ones. At n = 4 the stimulus sweeps every one of the 65,536 operand pairs back to back, so every carry pattern is covered, including all-ones times all-ones. At n = 8, random pairs with random valid gaps are mixed with the forced extreme pairs, and the idle cycles carry garbage operands to show that the held result does not move.

// File: rtl/wide_mul_split_pkg.sv
package wide_mul_split_pkg;
  // Number of sub-products the split produces (2 halves x 2 halves).
  localparam int unsigned SUB_PRODUCTS = 4;

  function automatic int unsigned full_prod_w(input int unsigned half_w);
    return 4 * half_w;
  endfunction

  function automatic int unsigned final_add_w(input int unsigned half_w);
    return 3 * half_w;
  endfunction
endpackage

// File: rtl/half_mul.sv
// Unsigned n x n multiplier; combinational shift-and-add.
module half_mul #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] prod
);
  always_comb begin
    prod = '0;
    for (int k = 0; k < W; k++) begin
      if (op_b[k]) prod = prod + ({{W{1'b0}}, op_a} << k);
    end
  end
endmodule

// File: rtl/csa_row.sv
// Row of 3:2 carry-save cells; carry_o[i] has weight 2^(i+1).
module csa_row #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  for (genvar i = 0; i < W; i++) begin : g_cell
    assign sum_o[i]   = in_a[i] ^ in_b[i] ^ in_c[i];
    assign carry_o[i] = (in_a[i] & in_b[i]) | (in_a[i] & in_c[i]) | (in_b[i] & in_c[i]);
  end
endmodule

// File: rtl/cp_adder.sv
// Final carry-propagate adder.
module cp_adder #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] add_a,
  input  logic [W-1:0] add_b,
  output logic [W-1:0] add_s
);
  assign add_s = add_a + add_b;
endmodule

// File: rtl/wide_mul_split.sv
module wide_mul_split
  import wide_mul_split_pkg::*;
#(
  parameter int unsigned HALF_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [2*HALF_W-1:0]   a_in,
  input  logic [2*HALF_W-1:0]   x_in,
  output logic                  out_valid,
  output logic [4*HALF_W-1:0]   prod_out
);
  localparam int unsigned N    = HALF_W;
  localparam int unsigned OPW  = 2 * N;
  localparam int unsigned PW   = full_prod_w(N);
  localparam int unsigned FAW  = final_add_w(N);
  localparam int unsigned NSUB = SUB_PRODUCTS;

  // Sub-product index: bit0 selects high half of A, bit1 selects high half of X.
  // 0 = AL*XL, 1 = AH*XL, 2 = AL*XH, 3 = AH*XH
  logic [OPW-1:0] sub_p [NSUB];

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    logic [N-1:0] a_half, x_half;
    assign a_half = (g % 2 == 1) ? a_in[OPW-1:N] : a_in[N-1:0];
    assign x_half = (g / 2 == 1) ? x_in[OPW-1:N] : x_in[N-1:0];
    half_mul #(.W(N)) u_mul (
      .op_a (a_half),
      .op_b (x_half),
      .prod (sub_p[g])
    );
  end

  // Stage 1 register: sub-products
  logic           s1_v_q, s1_v_d;
  logic [OPW-1:0] s1_p_q [NSUB];
  logic [OPW-1:0] s1_p_d [NSUB];

  always_comb begin
    s1_v_d = in_valid;
    for (int k = 0; k < NSUB; k++) begin
      s1_p_d[k] = in_valid ? sub_p[k] : s1_p_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q <= 1'b0;
      for (int k = 0; k < NSUB; k++) s1_p_q[k] <= '0;
    end else begin
      s1_v_q <= s1_v_d;
      if (in_valid) begin
        for (int k = 0; k < NSUB; k++) s1_p_q[k] <= s1_p_d[k];
      end
    end
  end

  // Matrix: row0 = {HH, LL}, rows 1 and 2 = cross products shifted by N.
  logic [OPW-1:0] centre_row;
  logic [OPW-1:0] csa_sum, csa_carry;
  logic [FAW-1:0] fa_op_a, fa_op_b, fa_sum;

  assign centre_row = {s1_p_q[3][N-1:0], s1_p_q[0][OPW-1:N]};

  csa_row #(.W(OPW)) u_csa (
    .in_a    (centre_row),
    .in_b    (s1_p_q[1]),
    .in_c    (s1_p_q[2]),
    .sum_o   (csa_sum),
    .carry_o (csa_carry)
  );

  assign fa_op_a = {s1_p_q[3][OPW-1:N], csa_sum};
  assign fa_op_b = {{(N-1){1'b0}}, csa_carry, 1'b0};

  cp_adder #(.W(FAW)) u_cpa (
    .add_a (fa_op_a),
    .add_b (fa_op_b),
    .add_s (fa_sum)
  );

  // Stage 2 register: final product
  logic          s2_v_d;
  logic [PW-1:0] s2_p_d;

  always_comb begin
    s2_v_d = s1_v_q;
    s2_p_d = s1_v_q ? {fa_sum, s1_p_q[0][N-1:0]} : prod_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      prod_out  <= '0;
    end else begin
      out_valid <= s2_v_d;
      if (s1_v_q) prod_out <= s2_p_d;
    end
  end
endmodule

// File: rtl/wide_mul_split_chk.sv
module wide_mul_split_chk #(
  parameter int unsigned HALF_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [2*HALF_W-1:0] a_in,
  input logic [2*HALF_W-1:0] x_in,
  input logic                out_valid,
  input logic [4*HALF_W-1:0] prod_out
);
  localparam int unsigned N  = HALF_W;
  localparam int unsigned PW = 4 * N;

  logic [PW-1:0] a_ext, x_ext;
  logic [N-1:0]  a_lo, x_lo;
  assign a_ext = {{(2*N){1'b0}}, a_in};
  assign x_ext = {{(2*N){1'b0}}, x_in};
  assign a_lo  = a_in[N-1:0];
  assign x_lo  = x_in[N-1:0];

  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  a_r2_full_product: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (prod_out == $past(a_ext, 2) * $past(x_ext, 2)));

  a_r3_low_bits_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (prod_out[N-1:0] == N'($past(a_lo, 2) * $past(x_lo, 2))));

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(prod_out));
endmodule

bind wide_mul_split wide_mul_split_chk #(.HALF_W(HALF_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .a_in      (a_in),
  .x_in      (x_in),
  .out_valid (out_valid),
  .prod_out  (prod_out)
);

// File: tb/wide_mul_split_tb_top.sv
`timescale 1ns/1ps
module wide_mul_split_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // n = 4 instance
  logic        v4 = 1'b0;
  logic [7:0]  a4 = '0, x4 = '0;
  logic        ov4;
  logic [15:0] p4;
  // n = 8 instance
  logic        v8 = 1'b0;
  logic [15:0] a8 = '0, x8 = '0;
  logic        ov8;
  logic [31:0] p8;

  wide_mul_split #(.HALF_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(v4), .a_in(a4), .x_in(x4),
    .out_valid(ov4), .prod_out(p4));

  wide_mul_split #(.HALF_W(8)) dut8_i (
    .clk(clk), .rst_n(rst_n), .in_valid(v8), .a_in(a8), .x_in(x8),
    .out_valid(ov8), .prod_out(p8));

  int total = 0;
  int bad   = 0;
  string tag4 = "R2";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: two-deep delay line of {valid, product}, plus held result.
  bit          m4_v1, m4_v2;
  logic [15:0] m4_p1, m4_p2, m4_hold;
  bit          m8_v1, m8_v2;
  logic [31:0] m8_p1, m8_p2, m8_hold;

  always @(posedge clk) begin
    if (!rst_n) begin
      m4_v1 = 0; m4_v2 = 0; m4_p1 = '0; m4_p2 = '0; m4_hold = '0;
      m8_v1 = 0; m8_v2 = 0; m8_p1 = '0; m8_p2 = '0; m8_hold = '0;
    end else begin
      m4_v2 = m4_v1; m4_p2 = m4_p1;
      m4_v1 = v4;    m4_p1 = 16'(a4) * 16'(x4);
      if (m4_v2) m4_hold = m4_p2;
      m8_v2 = m8_v1; m8_p2 = m8_p1;
      m8_v1 = v8;    m8_p1 = 32'(a8) * 32'(x8);
      if (m8_v2) m8_hold = m8_p2;
    end
  end

  // Compare on every clock, away from the active edge.
  bit started = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      check(ov4 == 1'b0 && ov8 == 1'b0, "R4", "valid in reset", {62'd0, ov4, ov8}, 64'd0);
      check(p4 == '0 && p8 == '0, "R4", "product in reset", {16'd0, p8, p4}, 64'd0);
    end else if (started) begin
      check(ov4 == m4_v2, "R1", "n4 out_valid", 64'(ov4), 64'(m4_v2));
      check(ov8 == m8_v2, "R1", "n8 out_valid", 64'(ov8), 64'(m8_v2));
      if (m4_v2) begin
        check(p4 == m4_hold, tag4, "n4 product", 64'(p4), 64'(m4_hold));
        check(p4[3:0] == m4_hold[3:0], "R3", "n4 low bits", 64'(p4[3:0]), 64'(m4_hold[3:0]));
      end else begin
        check(p4 == m4_hold, "R5", "n4 held product", 64'(p4), 64'(m4_hold));
      end
      if (m8_v2) begin
        check(p8 == m8_hold, "R7", "n8 product", 64'(p8), 64'(m8_hold));
        check(p8[7:0] == m8_hold[7:0], "R3", "n8 low bits", 64'(p8[7:0]), 64'(m8_hold[7:0]));
      end else begin
        check(p8 == m8_hold, "R5", "n8 held product", 64'(p8), 64'(m8_hold));
      end
    end
  end

  task automatic drive8_random();
    v8 = ($urandom % 4) != 0;
    a8 = 16'($urandom);
    x8 = 16'($urandom);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    started = 1;

    // Extremes and garbage-while-idle (R2, R5, R7)
    @(negedge clk); v4 = 1; a4 = 8'hFF; x4 = 8'hFF; v8 = 1; a8 = 16'hFFFF; x8 = 16'hFFFF;
    @(negedge clk); v4 = 1; a4 = 8'h00; x4 = 8'hA5; v8 = 1; a8 = 16'hFFFF; x8 = 16'h0001;
    @(negedge clk); v4 = 1; a4 = 8'h0F; x4 = 8'hF0; v8 = 1; a8 = 16'h00FF; x8 = 16'hFF00;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      v4 = 0; a4 = 8'($urandom); x4 = 8'($urandom);
      v8 = 0; a8 = 16'($urandom); x8 = 16'($urandom);
    end

    // Exhaustive back-to-back sweep at n = 4 (R6); random traffic at n = 8 (R7)
    tag4 = "R6";
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk);
      v4 = 1; a4 = 8'(i >> 8); x4 = 8'(i);
      drive8_random();
    end
    @(negedge clk); v4 = 0; v8 = 0;
    tag4 = "R2";

    // Sparse traffic at both widths
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      v4 = ($urandom % 3) == 0; a4 = 8'($urandom); x4 = 8'($urandom);
      drive8_random();
    end
    @(negedge clk); v4 = 0; v8 = 0;
    repeat (4) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule